// File: doc/BRIEF.md
# Long-Press Push-Button Reset Controller

This block turns a deliberate long press on one or two active-low push buttons into an active-low system reset, while ignoring ordinary short presses. The button inputs are first brought into the clock domain through a two-stage synchronizer. A setup timer then counts clock ticks only while the qualifying press is held. A single button qualifies when it is low. With two buttons, both must be low. If the press breaks before the setup count is reached, the count starts again from zero.

Once the setup count is reached, the reset output goes low. A static parameter selects how the pulse ends. In fixed mode the pulse lasts a set number of ticks, whatever the buttons do. In release mode the pulse lasts until any monitored button is seen high again. After a pulse, a held button cannot start a new setup: every monitored input must first return high. A toggle output can be enabled. It flips on every rising edge of the reset output, so a downstream enable changes state once per completed long press.

The controller is a four-state machine: REARM, ARMED, SETUP and PULSE. REARM→ARMED is taken when all monitored inputs are high. ARMED→SETUP is taken on a qualifying press, and the count clears at that point. SETUP→ARMED is taken when the press breaks, and SETUP→PULSE when the setup count completes. PULSE→REARM is taken either when the fixed count expires or when a button is released, depending on the mode. The power-on reset forces the machine to REARM and clears the toggle output.

Top module: `lprst_ctrl`

## Requirements
- R1: While `por_n_i` is low, `rst_n_o` is low and `latch_o` is 0. After the power-on reset is released, `rst_n_o` is high.
- R2: A press is qualifying when the monitored button is low (one-input configuration) or when both buttons are low (two-input configuration). Let the press be driven just before clock edge 1. If it is held for SETUP_TICKS+1 edges, `rst_n_o` falls after edge SETUP_TICKS+3. If it is held for only SETUP_TICKS edges, no reset occurs.
- R3: In the two-input configuration, if either input goes high during setup, the count clears. A reset then needs a fresh, unbroken hold of full length, and a single button held alone never causes a reset.
- R4: In fixed mode (RELEASE_MODE=0), `rst_n_o` stays low for exactly PULSE_TICKS cycles. Button changes during the pulse do not affect its length.
- R5: In release mode (RELEASE_MODE=1), `rst_n_o` stays low until any monitored input is released. It rises after the third clock edge that follows the release.
- R6: After a pulse ends, no new reset can occur until every monitored input has been high. A button still held at the end of a pulse causes no further reset.
- R7: With LATCH_EN=1, `latch_o` inverts in the same cycle that `rst_n_o` rises and is otherwise unchanged. With LATCH_EN=0, `latch_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all timing is counted in its ticks |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| btn_n_i | input | NUM_BTN | Push-button inputs, active low, asynchronous |
| rst_n_o | output | 1 | Reset output, active low |
| latch_o | output | 1 | Toggle output, flips at each end of a reset pulse |

## Verification
All latencies are counted from the negative clock edge at which the bench changes a button. A qualifying press produces the falling reset edge SETUP_TICKS+3 edges later. In fixed mode the rising edge follows PULSE_TICKS edges after the fall. In release mode the rising edge comes three edges after the release, and the toggle output changes in the same cycle as that rising edge. For every instance, the driver places the exact cycle number of each expected output change into a queue. The monitor samples the outputs on negative edges, timestamps every change it sees, and compares it with the head of that queue. Any change that arrives with no queued entry, or at a different cycle, counts as a failure, and so does an entry still left in a queue at the end.

// File: rtl/lprst_pkg.sv
package lprst_pkg;

    typedef enum logic [1:0] {
        ST_REARM = 2'd0,
        ST_ARMED = 2'd1,
        ST_SETUP = 2'd2,
        ST_PULSE = 2'd3
    } lprst_state_t;

endpackage

// File: rtl/lprst_sync.sv
module lprst_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Released buttons read high, so both stages reset to ones.
    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            meta_q   <= '1;
            stable_q <= '1;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/lprst_qual.sv
module lprst_qual #(
    parameter int NUM_BTN = 2
) (
    input  logic [NUM_BTN-1:0] btn_n_i,
    output logic               press_o,
    output logic               any_up_o,
    output logic               all_up_o
);
    generate
        if (NUM_BTN == 1) begin : g_single
            assign press_o  = !btn_n_i[0];
            assign any_up_o = btn_n_i[0];
            assign all_up_o = btn_n_i[0];
        end else begin : g_multi
            // A press qualifies only with every button held down.
            assign press_o  = (btn_n_i == '0);
            assign any_up_o = |btn_n_i;
            assign all_up_o = &btn_n_i;
        end
    endgenerate
endmodule

// File: rtl/lprst_toggle.sv
module lprst_toggle #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic pulse_end_i,
    output logic toggle_o
);
    generate
        if (ENABLE) begin : g_on
            logic tgl_q;
            always_ff @(posedge clk_i or negedge por_n_i) begin
                if (!por_n_i)         tgl_q <= 1'b0;
                else if (pulse_end_i) tgl_q <= !tgl_q;
            end
            assign toggle_o = tgl_q;
        end else begin : g_off
            logic unused_end;
            assign unused_end = pulse_end_i;
            assign toggle_o   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/lprst_ctrl.sv
module lprst_ctrl
    import lprst_pkg::*;
#(
    parameter int NUM_BTN      = 2,
    parameter bit RELEASE_MODE = 1'b0,
    parameter bit LATCH_EN     = 1'b1,
    parameter int SETUP_TICKS  = 196608,
    parameter int PULSE_TICKS  = 10486
) (
    input  logic               clk_i,
    input  logic               por_n_i,
    input  logic [NUM_BTN-1:0] btn_n_i,
    output logic               rst_n_o,
    output logic               latch_o
);
    localparam int MAX_TICKS = (SETUP_TICKS > PULSE_TICKS) ? SETUP_TICKS : PULSE_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_TICKS - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);

    logic [NUM_BTN-1:0] btn_s;
    logic               press, any_up, all_up;
    lprst_state_t       st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               pulse_end;

    lprst_sync #(.WIDTH(NUM_BTN)) sync_i (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .async_i (btn_n_i),
        .sync_o  (btn_s)
    );

    lprst_qual #(.NUM_BTN(NUM_BTN)) qual_i (
        .btn_n_i  (btn_s),
        .press_o  (press),
        .any_up_o (any_up),
        .all_up_o (all_up)
    );

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_REARM: begin
                if (all_up) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (press) begin
                    st_d  = ST_SETUP;
                    cnt_d = '0;
                end
            end
            ST_SETUP: begin
                if (!press) begin
                    st_d  = ST_ARMED;
                    cnt_d = '0;
                end else if (cnt_q == SETUP_LAST) begin
                    st_d  = ST_PULSE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PULSE: begin
                if (RELEASE_MODE) begin
                    if (any_up) st_d = ST_REARM;
                end else if (cnt_q == PULSE_LAST) begin
                    st_d  = ST_REARM;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_REARM;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q  <= ST_REARM;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        rst_n_o   = por_n_i && (st_q != ST_PULSE);
        pulse_end = (st_q == ST_PULSE) && (st_d != ST_PULSE);
    end

    lprst_toggle #(.ENABLE(LATCH_EN)) toggle_i (
        .clk_i       (clk_i),
        .por_n_i     (por_n_i),
        .pulse_end_i (pulse_end),
        .toggle_o    (latch_o)
    );
endmodule

// File: rtl/lprst_ctrl_chk.sv
module lprst_ctrl_chk #(
    parameter int NUM_BTN      = 2,
    parameter bit RELEASE_MODE = 1'b0,
    parameter bit LATCH_EN     = 1'b1,
    parameter int SETUP_TICKS  = 196608,
    parameter int PULSE_TICKS  = 10486
) (
    input logic               clk_i,
    input logic               por_n_i,
    input logic [NUM_BTN-1:0] btn_n_i,
    input logic               rst_n_o,
    input logic               latch_o
);
    logic        raw_press, raw_all_up, raw_any_up;
    logic [31:0] hold_cnt, low_cnt;
    logic        rearm_q, alive_q, rst_prev;

    assign raw_press  = (NUM_BTN == 1) ? !btn_n_i[0] : (btn_n_i == '0);
    assign raw_all_up = &btn_n_i;
    assign raw_any_up = |btn_n_i;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            hold_cnt <= '0;
            low_cnt  <= '0;
            rearm_q  <= 1'b0;
            alive_q  <= 1'b0;
            rst_prev <= 1'b0;
        end else begin
            alive_q  <= 1'b1;
            rst_prev <= rst_n_o;
            if (!raw_press)                hold_cnt <= '0;
            else if (hold_cnt != '1)       hold_cnt <= hold_cnt + 1;
            if (rst_n_o)                   low_cnt  <= '0;
            else                           low_cnt  <= low_cnt + 1;
            if (!rst_n_o)                  rearm_q  <= 1'b0;
            else if (raw_all_up)           rearm_q  <= 1'b1;
        end
    end

    // R1
    por_low_chk: assert property (@(posedge clk_i) !por_n_i |-> !rst_n_o);

    // R2
    long_hold_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_n_o) |-> (hold_cnt >= 32'(SETUP_TICKS)));

    // R4
    fixed_len_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!RELEASE_MODE && alive_q && rst_n_o && !rst_prev) |-> (low_cnt == 32'(PULSE_TICKS)));

    // R5
    release_end_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (RELEASE_MODE && alive_q && rst_n_o && !rst_prev) |-> $past(raw_any_up, 3));

    // R6
    no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_n_o) |-> rearm_q);

    // R7
    latch_edge_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$stable(latch_o) |-> (LATCH_EN && rst_n_o && !rst_prev));
endmodule

bind lprst_ctrl lprst_ctrl_chk #(
    .NUM_BTN      (NUM_BTN),
    .RELEASE_MODE (RELEASE_MODE),
    .LATCH_EN     (LATCH_EN),
    .SETUP_TICKS  (SETUP_TICKS),
    .PULSE_TICKS  (PULSE_TICKS)
) chk_i (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .btn_n_i (btn_n_i),
    .rst_n_o (rst_n_o),
    .latch_o (latch_o)
);

// File: tb/lprst_ctrl_tb_top.sv
module lprst_ctrl_tb_top;
    localparam int S = 20;
    localparam int P = 8;
    localparam int K_FALL = 0, K_RISE = 1, K_LAT = 2;

    typedef struct {
        int    kind;
        int    cyc;
        int    val;
        string req;
    } ev_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] btn_n = 2'b11;
    logic [2:0] rst_w, lat_w;
    logic [2:0] rst_prev, lat_prev;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         mon_en = 1'b0;
    bit         done = 1'b0;
    int         lat_v [3];
    ev_t        exp_q [3][$];

    always #4 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    // 0: two-input fixed, 1: two-input release (no toggle), 2: one-input fixed
    lprst_ctrl #(.NUM_BTN(2), .RELEASE_MODE(1'b0), .LATCH_EN(1'b1),
                 .SETUP_TICKS(S), .PULSE_TICKS(P)) dut_i (
        .clk_i(clk), .por_n_i(por_n), .btn_n_i(btn_n),
        .rst_n_o(rst_w[0]), .latch_o(lat_w[0]));

    lprst_ctrl #(.NUM_BTN(2), .RELEASE_MODE(1'b1), .LATCH_EN(1'b0),
                 .SETUP_TICKS(S), .PULSE_TICKS(P)) dut_rel_i (
        .clk_i(clk), .por_n_i(por_n), .btn_n_i(btn_n),
        .rst_n_o(rst_w[1]), .latch_o(lat_w[1]));

    lprst_ctrl #(.NUM_BTN(1), .RELEASE_MODE(1'b0), .LATCH_EN(1'b1),
                 .SETUP_TICKS(S), .PULSE_TICKS(P)) dut_one_i (
        .clk_i(clk), .por_n_i(por_n), .btn_n_i(btn_n[0:0]),
        .rst_n_o(rst_w[2]), .latch_o(lat_w[2]));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver side: push one expected pulse, with its toggle when enabled
    task automatic push_pulse(input int i, input int fall_c, input int rise_c,
                              input string req_f, input string req_r);
        exp_q[i].push_back('{K_FALL, fall_c, 0, req_f});
        exp_q[i].push_back('{K_RISE, rise_c, 1, req_r});
        if (i != 1) begin
            lat_v[i] = 1 - lat_v[i];
            exp_q[i].push_back('{K_LAT, rise_c, lat_v[i], "R7"});
        end
    endtask

    task automatic got(input int i, input int kind, input int val);
        ev_t e;
        if (exp_q[i].size() == 0) begin
            check(1'b0, "R2 R3 R6 R7", $sformatf("dut%0d unexpected event kind %0d at cycle", i, kind),
                  cyc, -1);
        end else begin
            e = exp_q[i].pop_front();
            check(e.kind == kind && e.cyc == cyc && e.val == val, e.req,
                  $sformatf("dut%0d kind %0d/%0d val %0d/%0d cycle", i, kind, e.kind, val, e.val),
                  cyc, e.cyc);
        end
    endtask

    // Monitor: timestamp every output change away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            for (int i = 0; i < 3; i++) begin
                if (rst_w[i] != rst_prev[i]) begin
                    got(i, rst_w[i] ? K_RISE : K_FALL, int'(rst_w[i]));
                    rst_prev[i] = rst_w[i];
                end
                if (lat_w[i] != lat_prev[i]) begin
                    got(i, K_LAT, int'(lat_w[i]));
                    lat_prev[i] = lat_w[i];
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        int t;
        for (int i = 0; i < 3; i++) lat_v[i] = 0;
        idle(3);
        for (int i = 0; i < 3; i++) begin
            check(rst_w[i] == 1'b0, "R1", $sformatf("dut%0d rst during por", i), rst_w[i], 0);
            check(lat_w[i] == 1'b0, "R1", $sformatf("dut%0d latch during por", i), lat_w[i], 0);
        end
        por_n = 1'b1;
        idle(5);
        for (int i = 0; i < 3; i++)
            check(rst_w[i] == 1'b1, "R1", $sformatf("dut%0d rst after por", i), rst_w[i], 1);
        rst_prev = rst_w;
        lat_prev = lat_w;
        mon_en = 1'b1;

        // R2: held for exactly S edges -> nothing anywhere
        btn_n = 2'b00;
        idle(S);
        btn_n = 2'b11;
        idle(12);

        // R2 R4 R5 R6: long hold, release well after the fixed pulses
        btn_n = 2'b00;
        t = cyc;
        push_pulse(0, t + S + 3, t + S + 3 + P, "R2", "R4");
        push_pulse(2, t + S + 3, t + S + 3 + P, "R2", "R4");
        push_pulse(1, t + S + 3, t + 2 * S + P + 10 + 3, "R2", "R5");
        idle(2 * S + P + 10);
        btn_n = 2'b11;
        idle(12);

        // R3: second button blips up mid-setup, count restarts in two-input parts
        btn_n = 2'b00;
        t = cyc;
        push_pulse(2, t + S + 3, t + S + 3 + P, "R2", "R4");
        push_pulse(0, t + 10 + S + 6, t + 10 + S + 6 + P, "R3", "R4");
        push_pulse(1, t + 10 + S + 6, t + 10 + S + 6 + P + 10 + 3, "R3", "R5");
        idle(10);
        btn_n = 2'b10;
        idle(3);
        btn_n = 2'b00;
        idle(S + 3 + P + 10);
        btn_n = 2'b11;
        idle(12);

        // R4 R5: one button released during the pulse
        btn_n = 2'b00;
        t = cyc;
        push_pulse(0, t + S + 3, t + S + 3 + P, "R2", "R4");
        push_pulse(2, t + S + 3, t + S + 3 + P, "R2", "R4");
        push_pulse(1, t + S + 3, t + S + 8, "R2", "R5");
        idle(S + 5);
        btn_n = 2'b10;
        idle(P + 5);
        btn_n = 2'b11;
        idle(12);

        // R3: only one button held -> only the one-input part resets
        btn_n = 2'b10;
        t = cyc;
        push_pulse(2, t + S + 3, t + S + 3 + P, "R2", "R4");
        idle(2 * S + P + 10);
        btn_n = 2'b11;
        idle(12);

        for (int i = 0; i < 3; i++)
            check(exp_q[i].size() == 0, "R2 R4 R5 R7",
                  $sformatf("dut%0d events still pending", i), exp_q[i].size(), 0);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired at cycle", cyc, 0);
            report();
        end
    end
endmodule